// File: doc/BRIEF.md
# Chain Scan Bit-Stream Sequencer

This block turns one register access on a daisy chain of identical test-port devices into the TMS/TDI bit sequence that drives the chain, one bit per clock. The caller supplies a per-device select mask, an instruction code and a payload. The payload holds data only for the selected devices. For instruction loads, the block gives every unselected device a fallback code. For data scans, it puts a single filler bit in the stream for each unselected device. The bit returned from the chain in a filler position is dropped, so the result vector is packed like the payload.

A multi-scan mode lets a caller run repeated data scans without passing through the idle state between them. The first scan stops in Pause-DR. Each further scan leaves the pause, updates, spends exactly one clock in Run-Test-Idle, shifts again and parks again. A closing command returns the chain to Run-Test-Idle. The emitted bits go to a streaming sink. The TDO bit that belongs to each emitted bit is presented on `tdo` in the same cycle as that bit.

Top module: `jcs_seq`

## Requirements
- R1: After reset, `bit_valid`, `tms`, `tdi`, `busy` and `done` are low and `dout` is all zeros.
- R2: The op codes are 0 = instruction load, 1 = data scan, 2 = open multi-scan, 3 = step multi-scan and 4 = close multi-scan. An instruction load emits TMS 1,1,0,0, then NDEV*IR_LEN shift bits, then 1,0. Every shift bit has TMS 0 except the last one, which has TMS 1.
- R3: The shift bits of an instruction load present device NDEV-1 first and device 0 last, with each device's code sent LSB first. A device whose mask bit is 1 receives `instr`.
- R4: A device whose mask bit is 0 receives CODE_CLAMP when `instr` equals CODE_EXTEST or CODE_INTEST, and CODE_BYPASS (all ones by default) for any other instruction.
- R5: A data scan emits TMS 1,0,0, then L shift bits, then 1,0. L = k*DR_LEN + (NDEV-k), where k is the number of selected devices. Only the last shift bit has TMS 1.
- R6: The shift bits of a data scan run from device NDEV-1 down to device 0. A selected device takes DR_LEN payload bits, LSB first, from payload slot p, which is bits [p*DR_LEN +: DR_LEN]. Here p is the number of selected devices with a lower index. An unselected device takes one filler bit of value 0. TDI is 0 on every non-shift bit.
- R7: In a data scan, the `tdo` value present during each payload shift bit is stored in `dout` at that bit's payload position. The `tdo` values present during filler bits are discarded. Slots with no selected device read 0. `dout` is cleared when any op other than an instruction load is accepted, and an instruction load leaves `dout` unchanged.
- R8: Opening a multi-scan emits TMS 1,0,0, then the shift bits laid out as in R6 with TMS 1 on the last one, then a single 0 that parks the chain in Pause-DR.
- R9: Stepping a multi-scan emits TMS 1,1,0,1,0,0, then the R6 shift bits, then a single 0.
- R10: Closing a multi-scan emits TMS 1,1,0 and no shift bits.
- R11: A `start` is ignored, with no bits emitted and `busy` staying low, in any of these cases: the block is busy; the op is a step or close and no multi-scan is open; the op is a load, scan or open while a multi-scan is open; or the op code is 5 to 7.
- R12: `busy` rises in the cycle after an accepted `start`, and the first bit appears in the cycle after that. `done` pulses for one cycle, with `busy` low, in the cycle after the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a sequence (sampled while idle) |
| op | input | 3 | Sequence kind, encoded as in R2 |
| sel_mask | input | NDEV | Per-device select, bit i = device i |
| instr | input | IR_LEN | Instruction for selected devices |
| din | input | NDEV*DR_LEN | Packed payload for selected devices |
| tdo | input | 1 | Chain output belonging to the current bit |
| tms | output | 1 | Mode-select bit |
| tdi | output | 1 | Data bit into the chain |
| bit_valid | output | 1 | A TMS/TDI pair is presented this cycle |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| dout | output | NDEV*DR_LEN | Packed returned data for selected devices |

## Verification
Instruction loads are run three ways: with an ordinary code, with a boundary-test code and with the other boundary-test code. Comparing them shows whether the fallback code is chosen per instruction rather than fixed. Data scans use a scattered mask, an empty mask and a full mask. The empty and full masks separate filler handling from payload indexing at both extremes of L, and random `tdo` shows whether dropped filler bits shift the packed result. A multi-scan open, two steps and a close confirm the pause walks and that the same payload re-shifts correctly. Starts issued while busy, with illegal codes, or out of order with respect to the multi-scan state must leave the bit stream silent.

// File: rtl/jcs_pkg.sv
package jcs_pkg;

  typedef enum logic [2:0] {
    OP_IR       = 3'd0,
    OP_DR       = 3'd1,
    OP_MS_OPEN  = 3'd2,
    OP_MS_STEP  = 3'd3,
    OP_MS_CLOSE = 3'd4
  } jcs_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_FIN
  } jcs_state_e;

  // TMS lead-in pattern, emitted LSB first
  function automatic logic [5:0] head_bits(input jcs_op_e op);
    case (op)
      OP_IR:       head_bits = 6'b000011;
      OP_DR:       head_bits = 6'b000001;
      OP_MS_OPEN:  head_bits = 6'b000001;
      OP_MS_STEP:  head_bits = 6'b001011;
      OP_MS_CLOSE: head_bits = 6'b000011;
      default:     head_bits = 6'b000000;
    endcase
  endfunction

  function automatic logic [2:0] head_len(input jcs_op_e op);
    case (op)
      OP_IR:      head_len = 3'd4;
      OP_MS_STEP: head_len = 3'd6;
      default:    head_len = 3'd3;
    endcase
  endfunction

  // TMS tail pattern after the last shift bit, emitted LSB first
  function automatic logic [1:0] tail_bits(input jcs_op_e op);
    case (op)
      OP_IR, OP_DR: tail_bits = 2'b01;
      default:      tail_bits = 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] tail_len(input jcs_op_e op);
    case (op)
      OP_IR, OP_DR:           tail_len = 2'd2;
      OP_MS_OPEN, OP_MS_STEP: tail_len = 2'd1;
      default:                tail_len = 2'd0;
    endcase
  endfunction

  function automatic logic op_allowed(input logic [2:0] op, input logic parked);
    case (op)
      3'd0, 3'd1, 3'd2: op_allowed = !parked;
      3'd3, 3'd4:       op_allowed = parked;
      default:          op_allowed = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/jcs_cursor.sv
// Walks the chain from the device nearest TDO (NDEV-1) down to device 0,
// tracking the bit inside the current device's segment and the packed
// payload slot of the current device.
module jcs_cursor #(
  parameter int NDEV   = 8,
  parameter int IR_LEN = 4,
  parameter int DR_LEN = 8,
  parameter int BW     = 4,
  parameter int CW     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            step,
  input  logic            ir_mode_in,
  input  logic [NDEV-1:0] mask_in,
  output logic [BW-1:0]   bitn,
  output logic [CW-1:0]   pcnt,
  output logic            dev_sel,
  output logic            last
);

  localparam int DW = $clog2(NDEV);

  logic [NDEV-1:0] mask_r;
  logic            ir_r;
  logic [DW-1:0]   dev_r;
  logic [DW-1:0]   dev_nx;
  logic [BW-1:0]   bit_r;
  logic [CW-1:0]   pcnt_r;
  logic [BW-1:0]   seg_end;
  logic            end_dev;

  function automatic int popc(input logic [NDEV-1:0] m);
    int n;
    n = 0;
    for (int i = 0; i < NDEV; i++) n += int'(m[i]);
    return n;
  endfunction

  always_comb begin
    dev_nx  = dev_r - DW'(1);
    if (ir_r)              seg_end = BW'(IR_LEN - 1);
    else if (mask_r[dev_r]) seg_end = BW'(DR_LEN - 1);
    else                   seg_end = '0;
    end_dev = (bit_r == seg_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_r <= '0;
      ir_r   <= 1'b0;
      dev_r  <= '0;
      bit_r  <= '0;
      pcnt_r <= '0;
    end else if (load) begin
      mask_r <= mask_in;
      ir_r   <= ir_mode_in;
      dev_r  <= DW'(NDEV - 1);
      bit_r  <= '0;
      pcnt_r <= CW'(popc(mask_in)) - CW'(mask_in[NDEV-1]);
    end else if (step) begin
      if (end_dev) begin
        bit_r <= '0;
        if (dev_r != '0) begin
          dev_r  <= dev_nx;
          pcnt_r <= pcnt_r - CW'(mask_r[dev_nx]);
        end
      end else begin
        bit_r <= bit_r + BW'(1);
      end
    end
  end

  assign bitn    = bit_r;
  assign pcnt    = pcnt_r;
  assign dev_sel = mask_r[dev_r];
  assign last    = end_dev && (dev_r == '0);

endmodule

// File: rtl/jcs_ir_bit.sv
// Picks the instruction bit for the current device: the caller's code for a
// selected device, a fallback code otherwise (clamp for boundary tests).
module jcs_ir_bit #(
  parameter int                IR_LEN      = 4,
  parameter logic [IR_LEN-1:0] CODE_BYPASS = '1,
  parameter logic [IR_LEN-1:0] CODE_CLAMP  = IR_LEN'(5),
  parameter logic [IR_LEN-1:0] CODE_EXTEST = IR_LEN'(0),
  parameter logic [IR_LEN-1:0] CODE_INTEST = IR_LEN'(9),
  localparam int               IBW         = (IR_LEN > 1) ? $clog2(IR_LEN) : 1
) (
  input  logic [IR_LEN-1:0] instr,
  input  logic              dev_sel,
  input  logic [IBW-1:0]    bitn,
  output logic              bit_o
);

  logic              boundary;
  logic [IR_LEN-1:0] fallback;
  logic [IR_LEN-1:0] code;

  always_comb begin
    boundary = (instr == CODE_EXTEST) || (instr == CODE_INTEST);
    fallback = boundary ? CODE_CLAMP : CODE_BYPASS;
    code     = dev_sel ? instr : fallback;
    bit_o    = code[bitn];
  end

endmodule

// File: rtl/jcs_capture.sv
// Collects returned payload bits into the packed result vector.
module jcs_capture #(
  parameter int W  = 64,
  parameter int XW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [XW-1:0] idx,
  input  logic          bit_i,
  output logic [W-1:0]  data
);

  always_ff @(posedge clk) begin
    if (rst)      data <= '0;
    else if (clr) data <= '0;
    else if (wr)  data[idx] <= bit_i;
  end

endmodule

// File: rtl/jcs_seq.sv
module jcs_seq
  import jcs_pkg::*;
#(
  parameter int                NDEV        = 8,
  parameter int                IR_LEN      = 4,
  parameter int                DR_LEN      = 8,
  parameter logic [IR_LEN-1:0] CODE_BYPASS = '1,
  parameter logic [IR_LEN-1:0] CODE_CLAMP  = IR_LEN'(5),
  parameter logic [IR_LEN-1:0] CODE_EXTEST = IR_LEN'(0),
  parameter logic [IR_LEN-1:0] CODE_INTEST = IR_LEN'(9)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [2:0]             op,
  input  logic [NDEV-1:0]        sel_mask,
  input  logic [IR_LEN-1:0]      instr,
  input  logic [NDEV*DR_LEN-1:0] din,
  input  logic                   tdo,
  output logic                   tms,
  output logic                   tdi,
  output logic                   bit_valid,
  output logic                   busy,
  output logic                   done,
  output logic [NDEV*DR_LEN-1:0] dout
);

  localparam int PW    = NDEV * DR_LEN;
  localparam int XW    = $clog2(PW);
  localparam int SEGMX = (IR_LEN > DR_LEN) ? IR_LEN : DR_LEN;
  localparam int BW    = $clog2(SEGMX + 1);
  localparam int CW    = $clog2(NDEV + 1);
  localparam int IBW   = (IR_LEN > 1) ? $clog2(IR_LEN) : 1;

  jcs_state_e        state_q;
  jcs_op_e           op_q;
  logic [IR_LEN-1:0] instr_q;
  logic [PW-1:0]     din_q;
  logic [5:0]        head_q;
  logic [2:0]        head_n_q;
  logic [1:0]        tail_q;
  logic [1:0]        tail_n_q;
  logic [2:0]        cnt_q;
  logic              parked_q;
  logic              shift_q;
  logic              cap_q;
  logic [XW-1:0]     cap_idx_q;
  logic              tms_q, tdi_q, bv_q, busy_q, done_q;

  logic              accept;
  logic              cur_step;
  logic [BW-1:0]     bitn;
  logic [CW-1:0]     pcnt;
  logic              dev_sel;
  logic              seg_last;
  logic              ir_bit;
  logic [XW-1:0]     pidx;
  logic              shift_bit;
  logic              dr_kind;

  assign accept   = (state_q == ST_IDLE) && start && op_allowed(op, parked_q);
  assign cur_step = (state_q == ST_SHIFT);
  assign dr_kind  = (op_q != OP_IR);

  jcs_cursor #(
    .NDEV(NDEV), .IR_LEN(IR_LEN), .DR_LEN(DR_LEN), .BW(BW), .CW(CW)
  ) u_cursor (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .step      (cur_step),
    .ir_mode_in(op == 3'd0),
    .mask_in   (sel_mask),
    .bitn      (bitn),
    .pcnt      (pcnt),
    .dev_sel   (dev_sel),
    .last      (seg_last)
  );

  jcs_ir_bit #(
    .IR_LEN(IR_LEN), .CODE_BYPASS(CODE_BYPASS), .CODE_CLAMP(CODE_CLAMP),
    .CODE_EXTEST(CODE_EXTEST), .CODE_INTEST(CODE_INTEST)
  ) u_ir_bit (
    .instr  (instr_q),
    .dev_sel(dev_sel),
    .bitn   (bitn[IBW-1:0]),
    .bit_o  (ir_bit)
  );

  jcs_capture #(.W(PW), .XW(XW)) u_capture (
    .clk  (clk),
    .rst  (rst),
    .clr  (accept && (op != 3'd0)),
    .wr   (cap_q),
    .idx  (cap_idx_q),
    .bit_i(tdo),
    .data (dout)
  );

  always_comb begin
    pidx = XW'(pcnt) * XW'(DR_LEN) + XW'(bitn);
    if (!dr_kind)     shift_bit = ir_bit;
    else if (dev_sel) shift_bit = din_q[pidx];
    else              shift_bit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_IR;
      instr_q   <= '0;
      din_q     <= '0;
      head_q    <= '0;
      head_n_q  <= '0;
      tail_q    <= '0;
      tail_n_q  <= '0;
      cnt_q     <= '0;
      parked_q  <= 1'b0;
      shift_q   <= 1'b0;
      cap_q     <= 1'b0;
      cap_idx_q <= '0;
      tms_q     <= 1'b0;
      tdi_q     <= 1'b0;
      bv_q      <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          done_q  <= 1'b0;
          bv_q    <= 1'b0;
          tms_q   <= 1'b0;
          tdi_q   <= 1'b0;
          shift_q <= 1'b0;
          cap_q   <= 1'b0;
          if (accept) begin
            op_q     <= jcs_op_e'(op);
            instr_q  <= instr;
            din_q    <= din;
            head_q   <= head_bits(jcs_op_e'(op));
            head_n_q <= head_len(jcs_op_e'(op));
            tail_q   <= tail_bits(jcs_op_e'(op));
            tail_n_q <= tail_len(jcs_op_e'(op));
            cnt_q    <= '0;
            busy_q   <= 1'b1;
            state_q  <= ST_HEAD;
            if (op == 3'd2) parked_q <= 1'b1;
            if (op == 3'd4) parked_q <= 1'b0;
          end
        end
        ST_HEAD: begin
          bv_q    <= 1'b1;
          tms_q   <= head_q[cnt_q];
          tdi_q   <= 1'b0;
          shift_q <= 1'b0;
          cap_q   <= 1'b0;
          if (cnt_q == head_n_q - 3'd1) begin
            cnt_q   <= '0;
            state_q <= (op_q == OP_MS_CLOSE) ? ST_FIN : ST_SHIFT;
          end else begin
            cnt_q <= cnt_q + 3'd1;
          end
        end
        ST_SHIFT: begin
          bv_q      <= 1'b1;
          tms_q     <= seg_last;
          tdi_q     <= shift_bit;
          shift_q   <= 1'b1;
          cap_q     <= dr_kind && dev_sel;
          cap_idx_q <= pidx;
          if (seg_last) begin
            cnt_q   <= '0;
            state_q <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          bv_q    <= 1'b1;
          tms_q   <= tail_q[cnt_q[0]];
          tdi_q   <= 1'b0;
          shift_q <= 1'b0;
          cap_q   <= 1'b0;
          if (cnt_q == 3'(tail_n_q) - 3'd1) state_q <= ST_FIN;
          else                               cnt_q   <= cnt_q + 3'd1;
        end
        ST_FIN: begin
          bv_q    <= 1'b0;
          tms_q   <= 1'b0;
          tdi_q   <= 1'b0;
          shift_q <= 1'b0;
          cap_q   <= 1'b0;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tms       = tms_q;
  assign tdi       = tdi_q;
  assign bit_valid = bv_q;
  assign busy      = busy_q;
  assign done      = done_q;

endmodule

// File: rtl/jcs_seq_chk.sv
module jcs_seq_chk (
  input logic clk,
  input logic rst,
  input logic bit_valid,
  input logic busy,
  input logic done,
  input logic tms,
  input logic tdi,
  input logic shift_flag
);

  // R12: no bits are emitted while the block is not busy
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bit_valid);

  // R12: completion is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12: completion directly follows an emitted bit
  p_done_after_bit_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bit_valid));

  // R12: busy is already low when done pulses
  p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R12 / R2: one quiet cycle after acceptance, then a first bit with TMS high
  p_first_bit_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !bit_valid ##1 (bit_valid && tms));

  // R6: TDI stays low outside shift bits
  p_tdi_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !shift_flag) |-> !tdi);

endmodule

bind jcs_seq jcs_seq_chk u_jcs_seq_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_valid (bit_valid),
  .busy      (busy),
  .done      (done),
  .tms       (tms),
  .tdi       (tdi),
  .shift_flag(shift_q)
);

// File: tb/tb_jcs_seq.sv
module tb_jcs_seq;

  localparam int NDEV = 8;
  localparam int IRL  = 4;
  localparam int DRL  = 8;
  localparam int PW   = NDEV * DRL;
  localparam logic [IRL-1:0] C_BYP = 4'hF;
  localparam logic [IRL-1:0] C_CLA = 4'h5;
  localparam logic [IRL-1:0] C_EXT = 4'h0;
  localparam logic [IRL-1:0] C_INT = 4'h9;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [2:0]      op = 3'd0;
  logic [NDEV-1:0] sel_mask = '0;
  logic [IRL-1:0]  instr = '0;
  logic [PW-1:0]   din = '0;
  logic            tdo = 1'b0;
  logic            tms, tdi, bit_valid, busy, done;
  logic [PW-1:0]   dout;

  jcs_seq #(
    .NDEV(NDEV), .IR_LEN(IRL), .DR_LEN(DRL),
    .CODE_BYPASS(C_BYP), .CODE_CLAMP(C_CLA), .CODE_EXTEST(C_EXT), .CODE_INTEST(C_INT)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .sel_mask(sel_mask),
    .instr(instr), .din(din), .tdo(tdo), .tms(tms), .tdi(tdi),
    .bit_valid(bit_valid), .busy(busy), .done(done), .dout(dout)
  );

  always #5 clk = ~clk;

  typedef struct {
    bit tms;
    bit tdi;
    int cap;
  } ev_t;

  ev_t         q[$];
  bit          m_bv, m_tms, m_tdi, m_busy, m_done, m_parked;
  int          m_cap;
  logic [PW-1:0] m_dout;
  int          vecs = 0;
  int          errs = 0;
  int          cycles = 0;
  string       tag = "R1";

  function automatic void pe(bit t, bit i, int c);
    ev_t e;
    e.tms = t; e.tdi = i; e.cap = c;
    q.push_back(e);
  endfunction

  function automatic bit legal(logic [2:0] o, bit parked);
    if (o <= 3'd2) return !parked;
    if (o <= 3'd4) return parked;
    return 1'b0;
  endfunction

  function automatic void build(logic [2:0] o, logic [NDEV-1:0] m,
                                logic [IRL-1:0] ins, logic [PW-1:0] d);
    int L, k, sc, p;
    logic [IRL-1:0] alt, code;
    case (o)
      3'd0: begin pe(1,0,-1); pe(1,0,-1); pe(0,0,-1); pe(0,0,-1); end
      3'd3: begin pe(1,0,-1); pe(1,0,-1); pe(0,0,-1); pe(1,0,-1); pe(0,0,-1); pe(0,0,-1); end
      3'd4: begin pe(1,0,-1); pe(1,0,-1); pe(0,0,-1); end
      default: begin pe(1,0,-1); pe(0,0,-1); pe(0,0,-1); end
    endcase
    if (o == 3'd0) begin
      alt = (ins == C_EXT || ins == C_INT) ? C_CLA : C_BYP;
      L = NDEV * IRL;
      k = 0;
      for (int dv = NDEV-1; dv >= 0; dv--) begin
        code = m[dv] ? ins : alt;
        for (int b = 0; b < IRL; b++) begin
          k++;
          pe(k == L, code[b], -1);
        end
      end
      pe(1,0,-1); pe(0,0,-1);
    end else if (o != 3'd4) begin
      sc = $countones(m);
      L = sc * DRL + NDEV - sc;
      k = 0;
      for (int dv = NDEV-1; dv >= 0; dv--) begin
        if (m[dv]) begin
          p = 0;
          for (int j = 0; j < dv; j++) if (m[j]) p++;
          for (int b = 0; b < DRL; b++) begin
            k++;
            pe(k == L, d[p*DRL+b], p*DRL+b);
          end
        end else begin
          k++;
          pe(k == L, 1'b0, -1);
        end
      end
      if (o == 3'd1) begin pe(1,0,-1); pe(0,0,-1); end
      else pe(0,0,-1);
    end
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    ev_t e;
    if (rst) begin
      q.delete();
      m_bv = 0; m_tms = 0; m_tdi = 0; m_cap = -1;
      m_busy = 0; m_done = 0; m_parked = 0; m_dout = '0;
    end else begin
      if (m_bv && m_cap >= 0) m_dout[m_cap] = tdo;
      if (m_busy) begin
        if (q.size() > 0) begin
          e = q.pop_front();
          m_bv = 1; m_tms = e.tms; m_tdi = e.tdi; m_cap = e.cap;
        end else begin
          m_bv = 0; m_tms = 0; m_tdi = 0; m_cap = -1;
          m_done = 1; m_busy = 0;
        end
      end else begin
        m_done = 0; m_bv = 0; m_tms = 0; m_tdi = 0; m_cap = -1;
        if (start && legal(op, m_parked)) begin
          m_busy = 1;
          if (op != 3'd0) m_dout = '0;
          if (op == 3'd2) m_parked = 1;
          if (op == 3'd4) m_parked = 0;
          build(op, sel_mask, instr, din);
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      vecs++;
      if ({bit_valid, tms, tdi, busy, done} !== {m_bv, m_tms, m_tdi, m_busy, m_done}
          || dout !== m_dout) begin
        errs++;
        $display("FAIL %s t=%0t {bv,tms,tdi,busy,done} act=%b exp=%b dout act=%h exp=%h",
                 tag, $time, {bit_valid, tms, tdi, busy, done},
                 {m_bv, m_tms, m_tdi, m_busy, m_done}, dout, m_dout);
      end
    end
  end

  always @(negedge clk) tdo <= 1'($urandom);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errs++;
      $display("FAIL R12 watchdog expired act=%0d cycles exp=<50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic issue(input string t, input logic [2:0] o, input logic [NDEV-1:0] m,
                       input logic [IRL-1:0] ins, input logic [PW-1:0] d, input bit poke);
    @(negedge clk);
    tag = t; op = o; sel_mask = m; instr = ins; din = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (poke && i == 3) begin
        op = 3'd0; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (m_done) break;
    end
    start = 1'b0;
    vecs++;
    if (!done) begin
      errs++;
      $display("FAIL %s completion act=%b exp=1", t, done);
    end
  endtask

  task automatic ignored(input string t, input logic [2:0] o);
    @(negedge clk);
    tag = t; op = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      vecs++;
      if (busy || bit_valid) begin
        errs++;
        $display("FAIL %s ignored start act busy=%b bv=%b exp=0/0", t, busy, bit_valid);
      end
    end
  endtask

  initial begin
    logic [PW-1:0] pay;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    vecs++;
    if (bit_valid || tms || tdi || busy || done || dout != '0) begin
      errs++;
      $display("FAIL R1 reset act=%b/%h exp=00000/0", {bit_valid, tms, tdi, busy, done}, dout);
    end

    issue("R2 R3 R4 R12", 3'd0, 8'b1010_0101, 4'h3, '0, 0);
    issue("R3 R4", 3'd0, 8'b0000_1111, C_EXT, '0, 0);
    issue("R4", 3'd0, 8'b0000_0000, C_INT, '0, 0);

    pay = {$urandom, $urandom};
    issue("R5 R6 R7 R12", 3'd1, 8'b1010_0101, 4'h3, pay, 1);
    issue("R6 R7", 3'd1, 8'h00, 4'h3, pay, 0);
    pay = {$urandom, $urandom};
    issue("R6 R7", 3'd1, 8'hFF, 4'h3, pay, 0);
    issue("R7", 3'd0, 8'hFF, 4'h3, '0, 0);

    ignored("R11", 3'd3);
    ignored("R11", 3'd4);
    ignored("R11", 3'd7);

    pay = {$urandom, $urandom};
    issue("R8 R6 R7", 3'd2, 8'b0011_1100, 4'h3, pay, 0);
    ignored("R11", 3'd0);
    ignored("R11", 3'd2);
    issue("R9", 3'd3, 8'b1000_0001, 4'h3, pay, 0);
    issue("R9", 3'd3, 8'b0110_0000, 4'h3, ~pay, 0);
    issue("R10", 3'd4, 8'h00, 4'h3, '0, 0);
    ignored("R11", 3'd3);
    issue("R5", 3'd1, 8'b0000_0001, 4'h3, pay, 0);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule